// File: doc/BRIEF.md
# Quad DAC serial register front-end

This block is the digital side of a four-channel, 16-bit voltage-output converter. A host writes 32-bit command words over a three-wire serial link: a serial clock, a data line and an active-low frame select. Each word lands in one of two register stages per channel. The input stage holds staged codes. The converter stage holds the code that feeds the analog output. Staged codes move to the output stage in one of three ways: through a low-active load pin, through dedicated commands, or through a one-shot software load mask.

A falling edge on the clear pin forces every channel to a programmable clear code. While the clear pin stays low, the load pin has no effect. A strap input chooses whether the channels come out of reset at zero or at midscale. A serial data output can be enabled so that several devices share one chain. It returns the previous word one bit per serial clock.

All serial and strobe pins are oversampled in the system clock domain through a parameterised synchronizer. Edges are detected after the synchronizer, so the serial clock must stay well below the system clock.

Top module: `qdac_frontend`

## Requirements
- R1: After reset every channel's input and output code is 0x0000 when `strap_mid` is low and 0x8000 when it is high. The power-down mask and mode read 0, and `sdo` is 0.
- R2: A frame starts when `fsync_n` falls and samples `sdin` on 32 falling edges of `sclk`, most significant bit first. Word bits 27:24 are the command, bits 23:20 the address, bits 19:4 the data and bits 3:0 the feature field. Bits 31:28 and command codes not listed here (such as 7) change nothing.
- R3: If `fsync_n` rises before the 32nd falling edge, the partial word has no effect.
- R4: Command 0 writes the data into the input register of the addressed channel and marks it pending. While `load_n` is high, the output codes do not change.
- R5: While `load_n` is low and `clr_n` is high, every pending channel copies its input code to its output code. If `load_n` is held low, the output follows a write right away.
- R6: Addresses 0 to 3 select one channel, 0xF selects all, and any other address selects none. Command 1 copies input to output for the selected channels. Command 2 writes the selected inputs and then copies every channel. Command 3 writes both stages of the selected channels.
- R7: A falling edge on `clr_n` loads the clear code into both stages of every channel. Command 5 sets the clear code from word bits 1:0: 0 gives 0x0000, 1 gives 0x8000 and 2 gives 0xFFFF. The value 3 is ignored, and the reset clear code is zero.
- R8: While `clr_n` is held low, `load_n` is ignored. Channels written in that time stay pending and move to the output on a later load.
- R9: Command 4 sets `pd_mode` from word bits 9:8 and `pd_mask` from word bits 3:0, where bit i stands for channel i.
- R10: Command 6 copies input to output once for every channel whose bit is set in word bits 3:0.
- R11: Command 8 sets chaining from word bit 0. When chaining is on, `sdo` shows the previous shift contents MSB first: it takes the top bit when a frame starts and then updates on each rising `sclk` edge. When chaining is off, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mid | input | 1 | Power-up code select: 0 for zero scale, 1 for midscale |
| sclk | input | 1 | Serial clock, idles high |
| fsync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out for chaining |
| load_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Clear input, falling-edge triggered |
| dac_codes | output | 64 | Output codes, channel i at bits 16i+15:16i |
| pd_mask | output | 4 | Per-channel power-down flags |
| pd_mode | output | 2 | Power-down mode |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit codes, 32-bit words and a two-stage synchronizer. With these values the word layout, the midscale and full-scale codes, and the 0xF broadcast address can all be checked with literal expected values. The serial clock is run at one twelfth of the system clock, which leaves room for the synchronizer and edge-detect latency. This makes it possible to sample `sdo` one bit per clock and compare it against the word shifted in during the previous frame. Two resets with opposite straps cover both power-up codes.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    parameter int CH_N   = 4;
    parameter int CODE_W = 16;
    parameter int WORD_W = 32;

    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam int CMD_LSB  = 24;
    localparam int ADDR_LSB = 20;
    localparam int DATA_LSB = 4;
    localparam int PDM_LSB  = 8;
    localparam logic [3:0] ADDR_ALL = 4'hF;

    typedef enum logic [3:0] {
        OP_WR_IN     = 4'd0,
        OP_LOAD      = 4'd1,
        OP_WR_LD_ALL = 4'd2,
        OP_WR_LD     = 4'd3,
        OP_PWR       = 4'd4,
        OP_CLR_CODE  = 4'd5,
        OP_SW_LOAD   = 4'd6,
        OP_CHAIN     = 4'd8
    } op_e;

    function automatic logic [CODE_W-1:0] clear_value(input logic [1:0] sel);
        logic [CODE_W-1:0] v;
        case (sel)
            2'd1:    v = {1'b1, {(CODE_W-1){1'b0}}};
            2'd2:    v = {CODE_W{1'b1}};
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int          STAGES  = 2,
    parameter int          WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/qdac_serial_rx.sv
module qdac_serial_rx
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              fsync_n_s,
    input  logic              sdin_s,
    input  logic              chain_en,
    output logic              word_valid,
    output logic [WORD_W-1:0] word,
    output logic              sdo
);
    typedef struct packed {
        logic              sclk_prev;
        logic              fsync_prev;
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic              sdo;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic sclk_fall, sclk_rise, frame_start;

    always_comb begin
        sclk_fall   = rx_q.sclk_prev & ~sclk_s;
        sclk_rise   = ~rx_q.sclk_prev & sclk_s;
        frame_start = rx_q.fsync_prev & ~fsync_n_s;

        rx_d            = rx_q;
        rx_d.sclk_prev  = sclk_s;
        rx_d.fsync_prev = fsync_n_s;
        rx_d.valid      = 1'b0;

        if (fsync_n_s) begin
            rx_d.cnt = '0;
        end else if (sclk_fall && (rx_q.cnt < CNT_W'(WORD_W))) begin
            rx_d.shreg = {rx_q.shreg[WORD_W-2:0], sdin_s};
            rx_d.cnt   = rx_q.cnt + 1'b1;
            if (rx_q.cnt == CNT_W'(WORD_W - 1)) begin
                rx_d.valid = 1'b1;
            end
        end

        if (!chain_en) begin
            rx_d.sdo = 1'b0;
        end else if (frame_start || sclk_rise) begin
            rx_d.sdo = rx_q.shreg[WORD_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q            <= '0;
            rx_q.sclk_prev  <= 1'b1;
            rx_q.fsync_prev <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign word_valid = rx_q.valid;
    assign word       = rx_q.shreg;
    assign sdo        = rx_q.sdo;

    // R2: a completed frame yields exactly one command strobe
    p_single_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R11: sdo only moves on a rising serial clock, a frame start or a chain change
    p_sdo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !frame_start && $stable(chain_en)) |=> $stable(sdo));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
    import qdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strap_mid,
    input  logic                     word_valid,
    input  logic [WORD_W-1:0]        word,
    input  logic                     load_n_s,
    input  logic                     clr_n_s,
    output logic [CH_N*CODE_W-1:0]   dac_codes,
    output logic [CH_N-1:0]          pd_mask,
    output logic [1:0]               pd_mode,
    output logic                     chain_en
);
    typedef struct packed {
        logic [CH_N-1:0][CODE_W-1:0] inreg;
        logic [CH_N-1:0][CODE_W-1:0] dac;
        logic [CH_N-1:0]             pend;
        logic [1:0]                  clr_sel;
        logic [CH_N-1:0]             pd_mask;
        logic [1:0]                  pd_mode;
        logic                        chain;
        logic                        clr_prev;
    } rg_t;

    rg_t               rg_d, rg_q;
    logic              clr_fall;
    logic [3:0]        op, addr;
    logic [CODE_W-1:0] data;
    logic [CH_N-1:0]   sel;
    logic [CODE_W-1:0] por_code;
    logic              unused_hi;

    assign op        = word[CMD_LSB +: 4];
    assign addr      = word[ADDR_LSB +: 4];
    assign data      = word[DATA_LSB +: CODE_W];
    assign unused_hi = ^word[WORD_W-1:CMD_LSB+4];
    assign por_code  = strap_mid ? clear_value(2'd1) : '0;

    always_comb begin
        for (int i = 0; i < CH_N; i++) begin
            sel[i] = (addr == ADDR_ALL) || (addr == 4'(i));
        end
    end

    always_comb begin
        clr_fall      = rg_q.clr_prev & ~clr_n_s;
        rg_d          = rg_q;
        rg_d.clr_prev = clr_n_s;

        if (clr_fall) begin
            for (int i = 0; i < CH_N; i++) begin
                rg_d.inreg[i] = clear_value(rg_q.clr_sel);
                rg_d.dac[i]   = clear_value(rg_q.clr_sel);
            end
            rg_d.pend = '0;
        end else begin
            if (word_valid) begin
                case (op)
                    OP_WR_IN: begin
                        for (int i = 0; i < CH_N; i++) begin
                            if (sel[i]) begin
                                rg_d.inreg[i] = data;
                                rg_d.pend[i]  = 1'b1;
                            end
                        end
                    end
                    OP_LOAD: begin
                        for (int i = 0; i < CH_N; i++) begin
                            if (sel[i]) begin
                                rg_d.dac[i]  = rg_q.inreg[i];
                                rg_d.pend[i] = 1'b0;
                            end
                        end
                    end
                    OP_WR_LD_ALL: begin
                        for (int i = 0; i < CH_N; i++) begin
                            if (sel[i]) begin
                                rg_d.inreg[i] = data;
                            end
                            rg_d.dac[i] = rg_d.inreg[i];
                        end
                        rg_d.pend = '0;
                    end
                    OP_WR_LD: begin
                        for (int i = 0; i < CH_N; i++) begin
                            if (sel[i]) begin
                                rg_d.inreg[i] = data;
                                rg_d.dac[i]   = data;
                                rg_d.pend[i]  = 1'b0;
                            end
                        end
                    end
                    OP_PWR: begin
                        rg_d.pd_mode = word[PDM_LSB +: 2];
                        rg_d.pd_mask = word[CH_N-1:0];
                    end
                    OP_CLR_CODE: begin
                        if (word[1:0] != 2'd3) begin
                            rg_d.clr_sel = word[1:0];
                        end
                    end
                    OP_SW_LOAD: begin
                        for (int i = 0; i < CH_N; i++) begin
                            if (word[i]) begin
                                rg_d.dac[i]  = rg_q.inreg[i];
                                rg_d.pend[i] = 1'b0;
                            end
                        end
                    end
                    OP_CHAIN: rg_d.chain = word[0];
                    default: ;
                endcase
            end
            if (!load_n_s && clr_n_s) begin
                for (int i = 0; i < CH_N; i++) begin
                    if (rg_d.pend[i]) begin
                        rg_d.dac[i]  = rg_d.inreg[i];
                        rg_d.pend[i] = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q          <= '0;
            rg_q.clr_prev <= 1'b1;
            for (int i = 0; i < CH_N; i++) begin
                rg_q.inreg[i] <= por_code;
                rg_q.dac[i]   <= por_code;
            end
        end else begin
            rg_q <= rg_d;
        end
    end

    for (genvar g = 0; g < CH_N; g++) begin : g_out
        assign dac_codes[g*CODE_W +: CODE_W] = rg_q.dac[g];
    end

    assign pd_mask  = rg_q.pd_mask;
    assign pd_mode  = rg_q.pd_mode;
    assign chain_en = rg_q.chain;

    logic [CH_N-1:0] pend_q;
    logic [1:0]      clr_sel_q;
    assign pend_q    = rg_q.pend;
    assign clr_sel_q = rg_q.clr_sel;

    // R4: with the strobe high and no command or clear, outputs stay put
    p_load_high_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && !word_valid && !clr_fall) |=> $stable(dac_codes));

    // R5: a low strobe with clear released leaves nothing pending
    p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n_s && clr_n_s) |=> (pend_q == '0));

    // R8: a held clear freezes the outputs against the strobe
    p_load_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n_s && !word_valid && !clr_fall) |=> $stable(dac_codes));

    for (genvar g = 0; g < CH_N; g++) begin : g_chk
        // R7: every channel takes the clear code after a clear edge
        p_clear_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_fall |=> (dac_codes[g*CODE_W +: CODE_W] == clear_value($past(clr_sel_q))));
    end
endmodule

// File: rtl/qdac_frontend.sv
module qdac_frontend
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strap_mid,
    input  logic                   sclk,
    input  logic                   fsync_n,
    input  logic                   sdin,
    output logic                   sdo,
    input  logic                   load_n,
    input  logic                   clr_n,
    output logic [CH_N*CODE_W-1:0] dac_codes,
    output logic [CH_N-1:0]        pd_mask,
    output logic [1:0]             pd_mode
);
    localparam int         PIN_N    = 5;
    localparam logic [PIN_N-1:0] PIN_IDLE = 5'b11011;

    logic [PIN_N-1:0]  pins_s;
    logic              word_valid;
    logic [WORD_W-1:0] word;
    logic              chain_en;

    qdac_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (PIN_N),
        .RST_VAL (PIN_IDLE)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, fsync_n, sdin, load_n, clr_n}),
        .q     (pins_s)
    );

    qdac_serial_rx i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[4]),
        .fsync_n_s  (pins_s[3]),
        .sdin_s     (pins_s[2]),
        .chain_en   (chain_en),
        .word_valid (word_valid),
        .word       (word),
        .sdo        (sdo)
    );

    qdac_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_mid  (strap_mid),
        .word_valid (word_valid),
        .word       (word),
        .load_n_s   (pins_s[1]),
        .clr_n_s    (pins_s[0]),
        .dac_codes  (dac_codes),
        .pd_mask    (pd_mask),
        .pd_mode    (pd_mode),
        .chain_en   (chain_en)
    );
endmodule

// File: tb/test_qdac_frontend.sv
module test_qdac_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_mid = 1'b1;
    logic        sclk = 1'b1;
    logic        fsync_n = 1'b1;
    logic        sdin = 1'b0;
    logic        load_n = 1'b1;
    logic        clr_n = 1'b1;
    logic        sdo;
    logic [63:0] dac_codes;
    logic [3:0]  pd_mask;
    logic [1:0]  pd_mode;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int popped = 0;
    logic [31:0] cap;

    typedef struct {
        logic [63:0] dac;
        logic [3:0]  mask;
        logic [1:0]  mode;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    qdac_frontend i_qdac_frontend (
        .clk(clk), .rst_n(rst_n), .strap_mid(strap_mid), .sclk(sclk),
        .fsync_n(fsync_n), .sdin(sdin), .sdo(sdo), .load_n(load_n),
        .clr_n(clr_n), .dac_codes(dac_codes), .pd_mask(pd_mask), .pd_mode(pd_mode)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_reset(input logic strap);
        strap_mid = strap;
        @(negedge clk);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic send_bits(input logic [31:0] w, input int nbits);
        fsync_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < nbits; i++) begin
            sdin = w[31-i];
            wait_clk(6);
            cap[31-i] = sdo;
            sclk = 1'b0;
            wait_clk(6);
            sclk = 1'b1;
        end
        wait_clk(6);
        fsync_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic frame(input logic [3:0] op, input logic [3:0] addr,
                         input logic [15:0] data, input logic [3:0] feat);
        send_bits({4'h0, op, addr, data, feat}, 32);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_clk(6);
        load_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic expect_state(input logic [15:0] c3, input logic [15:0] c2,
                                input logic [15:0] c1, input logic [15:0] c0,
                                input logic [3:0] m, input logic [1:0] md,
                                input string tag);
        exp_t e;
        e.dac  = {c3, c2, c1, c0};
        e.mask = m;
        e.mode = md;
        e.tag  = tag;
        exp_q.push_back(e);
        pushed++;
        wait (popped == pushed);
    endtask

    task automatic check_bit(input logic act, input logic expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, expv);
        end
    endtask

    task automatic check_word(input logic [31:0] act, input logic [31:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            exp_t e;
            wait (popped != pushed);
            e = exp_q[0];
            wait_clk(2);
            checks++;
            if (dac_codes !== e.dac || pd_mask !== e.mask || pd_mode !== e.mode) begin
                errors++;
                $display("FAIL %s: actual dac=%h mask=%h mode=%0d expected dac=%h mask=%h mode=%0d",
                         e.tag, dac_codes, pd_mask, pd_mode, e.dac, e.mask, e.mode);
            end
            void'(exp_q.pop_front());
            popped++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset(1'b1);
        expect_state(16'h8000, 16'h8000, 16'h8000, 16'h8000, 4'h0, 2'd0, "R1 midscale strap");
        check_bit(sdo, 1'b0, "R1 sdo after reset");

        frame(4'd0, 4'd1, 16'h1234, 4'h0);
        expect_state(16'h8000, 16'h8000, 16'h8000, 16'h8000, 4'h0, 2'd0, "R4 staged write");
        pulse_load();
        expect_state(16'h8000, 16'h8000, 16'h1234, 16'h8000, 4'h0, 2'd0, "R5 load pulse");

        send_bits({4'h0, 4'd3, 4'd0, 16'hDEAD, 4'h0}, 20);
        expect_state(16'h8000, 16'h8000, 16'h1234, 16'h8000, 4'h0, 2'd0, "R3 aborted frame");

        frame(4'd3, 4'd0, 16'hBEEF, 4'h0);
        expect_state(16'h8000, 16'h8000, 16'h1234, 16'hBEEF, 4'h0, 2'd0, "R2 R6 write and load");

        frame(4'd0, 4'hF, 16'h1111, 4'h0);
        frame(4'd1, 4'd2, 16'h0000, 4'h0);
        expect_state(16'h8000, 16'h1111, 16'h1234, 16'hBEEF, 4'h0, 2'd0, "R6 broadcast then load one");

        frame(4'd0, 4'd7, 16'h7777, 4'h0);
        frame(4'd2, 4'd3, 16'h3333, 4'h0);
        expect_state(16'h3333, 16'h1111, 16'h1111, 16'h1111, 4'h0, 2'd0, "R6 bad address and load all");

        frame(4'd4, 4'd0, 16'h0020, 4'h5);
        expect_state(16'h3333, 16'h1111, 16'h1111, 16'h1111, 4'h5, 2'd2, "R9 power-down");

        frame(4'd0, 4'd0, 16'hAAAA, 4'h0);
        frame(4'd0, 4'd3, 16'hBBBB, 4'h0);
        frame(4'd6, 4'd0, 16'h0000, 4'h8);
        expect_state(16'hBBBB, 16'h1111, 16'h1111, 16'h1111, 4'h5, 2'd2, "R10 software load mask");

        frame(4'd5, 4'd0, 16'h0000, 4'h3);
        clr_n = 1'b0;
        wait_clk(6);
        clr_n = 1'b1;
        wait_clk(4);
        expect_state(16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'h5, 2'd2, "R7 default zero clear");

        frame(4'd5, 4'd0, 16'h0000, 4'h2);
        clr_n = 1'b0;
        wait_clk(6);
        expect_state(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'h5, 2'd2, "R7 full-scale clear");
        frame(4'd0, 4'd1, 16'h4444, 4'h0);
        pulse_load();
        expect_state(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'h5, 2'd2, "R8 load ignored in clear");
        clr_n = 1'b1;
        wait_clk(6);
        pulse_load();
        expect_state(16'hFFFF, 16'hFFFF, 16'h4444, 16'hFFFF, 4'h5, 2'd2, "R8 pending kept");

        frame(4'd5, 4'd0, 16'h0000, 4'h1);
        clr_n = 1'b0;
        wait_clk(6);
        clr_n = 1'b1;
        wait_clk(4);
        expect_state(16'h8000, 16'h8000, 16'h8000, 16'h8000, 4'h5, 2'd2, "R7 midscale clear");

        load_n = 1'b0;
        wait_clk(6);
        frame(4'd0, 4'd2, 16'h2222, 4'h0);
        expect_state(16'h8000, 16'h2222, 16'h8000, 16'h8000, 4'h5, 2'd2, "R5 held-low follow");
        load_n = 1'b1;
        wait_clk(6);

        frame(4'd8, 4'd0, 16'h0000, 4'h1);
        send_bits(32'hA7C3_5A96, 32);
        send_bits(32'h0700_0000, 32);
        check_word(cap, 32'hA7C3_5A96, "R11 chained output");
        expect_state(16'h8000, 16'h2222, 16'h8000, 16'h8000, 4'h5, 2'd2, "R2 unknown command ignored");

        frame(4'd8, 4'd0, 16'h0000, 4'h0);
        send_bits(32'h07FF_FFFF, 32);
        check_word(cap, 32'h0000_0000, "R11 chain disabled");

        do_reset(1'b0);
        expect_state(16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'h0, 2'd0, "R1 zero strap");

        summary();
    end
endmodule